// File: doc/BRIEF.md
# Pin Interrupt Configuration and Status Bank

This block holds a bank of general-purpose pins. Each pin has its own small group of registers, which a simple memory-mapped bus reaches with a single-cycle write strobe and a registered read. Through these registers software sets the pin direction and its driven value, and reads back the pad level after a two-flop synchronizer. Each pin also watches its synchronized input for a trigger. The trigger is either an active level or a single edge, and a polarity bit picks which one.

A trigger feeds two independent paths. The first is a sticky status flag, which records only while capture is enabled and which software clears by writing one. The second is an interrupt request, which reaches the shared summary interrupt output only while the pin's interrupt enable is set and its routing code selects the processor. A pin can therefore interrupt without leaving a status record, or record status without interrupting. The summary output is the OR of all routed requests.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin has output enable 0, output value 0, interrupt configuration 0, status 0 and routing code 7, and the summary output is 0.
- R2: Bit 9 of the pad configuration register (pin base + 0x0) drives the pin's pad_oe. Bit 1 of the in/out register (base + 0x4) drives pad_out. Bit 0 of the in/out register reads the pad input after two clock stages of synchronization.
- R3: The status flag (bit 0 of base + 0xC) sets on a trigger only while capture enable (bit 3 of the interrupt configuration at base + 0x8) is 1.
- R4: Writing 1 to status bit 0 clears the flag unless a trigger occurs in the same cycle. Writing 0 leaves the flag unchanged.
- R5: In edge mode (interrupt configuration bit 2 = 1), polarity bit 1 = 1 triggers on a rising synchronized input and 0 triggers on a falling one. The opposite edge does not trigger.
- R6: In level mode (bit 2 = 0), the trigger is active while the synchronized input equals the polarity bit. While the level stays active, the request follows the input and the status flag reads 1 again after a clear.
- R7: Interrupt enable (bit 0) and capture enable are independent. With enable set and capture clear, the summary rises while status stays 0. With capture set and enable clear, status sets while the summary stays 0.
- R8: A pin's request reaches the summary only while its routing code (bits 2:0 at 0x400 + 4*pin) equals 4. Any other code blocks it. A pending edge request is kept, so routing it to 4 later raises the summary.
- R9: Pin registers sit at 0x1000 + 0x10*pin. Read data appears on the cycle after the read strobe and holds while no read is issued. Unmapped addresses, and pins beyond the bank, read as 0.
- R10: The summary output is the OR of all routed, enabled pin requests. Clearing one pending pin leaves the summary raised while another pin is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address of the register access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Driven pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| summary_irq | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that bus accesses are word aligned and that a read strobe and a write strobe are never asserted in the same cycle. They also assume that a pad input holds each level for at least three clocks, so that the synchronizer and the edge detector see every change. The stimulus drives the bus only through write and read tasks that pulse one strobe at a time. It changes a pad only on a falling clock edge and then waits four cycles before the next access, which lets each edge land in a known cycle. It also reconfigures polarity and mode only while the input sits at a level that cannot trigger under the new setting.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 32;
    localparam int ROUTE_W = 3;
    localparam int OE_BIT  = 9;

    localparam logic [ROUTE_W-1:0] ROUTE_APPS = 3'd4;
    localparam logic [ROUTE_W-1:0] ROUTE_OFF  = 3'd7;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PADCFG,
        RK_PADIO,
        RK_IRQCFG,
        RK_IRQSTAT,
        RK_ROUTE
    } reg_kind_e;

    // packed MSB first: bit3 capture, bit2 edge mode, bit1 polarity, bit0 enable
    typedef struct packed {
        logic cap;
        logic edge_md;
        logic pol;
        logic en;
    } irq_cfg_t;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] pin;
    } reg_sel_t;

    typedef struct packed {
        logic               oe;
        logic               out;
        logic               lvl;
        irq_cfg_t           icfg;
        logic               stat;
        logic [ROUTE_W-1:0] route;
    } pin_view_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int npins);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.pin  = '0;
        if (a[1:0] == 2'b00) begin
            if (a[12]) begin
                s.pin = a[11:4];
                if (int'(a[11:4]) < npins) begin
                    case (a[3:2])
                        2'd0:    s.kind = RK_PADCFG;
                        2'd1:    s.kind = RK_PADIO;
                        2'd2:    s.kind = RK_IRQCFG;
                        default: s.kind = RK_IRQSTAT;
                    endcase
                end
            end else if (a[12:10] == 3'b001) begin
                s.pin = a[9:2];
                if (int'(a[9:2]) < npins) s.kind = RK_ROUTE;
            end
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] format_read(input pin_view_t v, input reg_kind_e k);
        logic [DATA_W-1:0] w;
        w = '0;
        case (k)
            RK_PADCFG:  w[OE_BIT]        = v.oe;
            RK_PADIO:   w[1:0]           = {v.out, v.lvl};
            RK_IRQCFG:  w[3:0]           = v.icfg;
            RK_IRQSTAT: w[0]             = v.stat;
            RK_ROUTE:   w[ROUTE_W-1:0]   = v.route;
            default:    w                = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pad_in,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [DATA_W-1:0] wdata,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              irq_req,
    output pin_view_t         view
);
    logic               lvl;
    logic               prev;
    logic               oe_q;
    logic               out_q;
    irq_cfg_t           cfg_q;
    logic               stat_q;
    logic               pend_q;
    logic [ROUTE_W-1:0] route_q;
    logic               trig;
    logic               w1c;

    gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl)
    );

    always_comb begin
        if (cfg_q.edge_md)
            trig = cfg_q.pol ? (lvl & ~prev) : (~lvl & prev);
        else
            trig = (lvl == cfg_q.pol);
    end

    assign w1c = wr_en && (wr_kind == RK_IRQSTAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= 1'b0;
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            cfg_q   <= '0;
            route_q <= ROUTE_OFF;
        end else begin
            prev <= lvl;
            if (wr_en) begin
                case (wr_kind)
                    RK_PADCFG: oe_q    <= wdata[OE_BIT];
                    RK_PADIO:  out_q   <= wdata[1];
                    RK_IRQCFG: cfg_q   <= wdata[3:0];
                    RK_ROUTE:  route_q <= wdata[ROUTE_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // a trigger in the clearing cycle wins so no event is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (trig && cfg_q.cap) stat_q <= 1'b1;
            else if (w1c)          stat_q <= 1'b0;
            if (trig && cfg_q.en && cfg_q.edge_md) pend_q <= 1'b1;
            else if (w1c)                          pend_q <= 1'b0;
        end
    end

    assign irq_req = cfg_q.en && (route_q == ROUTE_APPS) && (cfg_q.edge_md ? pend_q : trig);
    assign pad_out = out_q;
    assign pad_oe  = oe_q;

    always_comb begin
        view.oe    = oe_q;
        view.out   = out_q;
        view.lvl   = lvl;
        view.icfg  = cfg_q;
        view.stat  = stat_q;
        view.route = route_q;
    end

    AST_STAT_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q) |-> $past(cfg_q.cap)) else $error("status set without capture"); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (w1c && !trig) |=> !stat_q) else $error("write-one clear ignored"); // R4

    AST_EDGE_RECORDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.cap && cfg_q.edge_md && trig) |=> stat_q) else $error("edge not recorded"); // R5

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_q == ROUTE_OFF && !pad_oe && !stat_q)) else $error("bad reset state"); // R1
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [12:0]         bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                summary_irq
);
    reg_sel_t          sel;
    pin_view_t         views [NUM_PINS];
    logic [NUM_PINS-1:0] req;
    logic [DATA_W-1:0] rd_word;

    assign sel = decode_addr(bus_addr, NUM_PINS);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic hit;
        assign hit = bus_wr && (sel.kind != RK_NONE) && (sel.pin == 8'(i));
        gpio_pin_unit u_pin (
            .clk     (clk),
            .rst     (rst),
            .pad_in  (pad_in[i]),
            .wr_en   (hit),
            .wr_kind (sel.kind),
            .wdata   (bus_wdata),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i]),
            .irq_req (req[i]),
            .view    (views[i])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (sel.pin == 8'(i)) rd_word = format_read(views[i], sel.kind);
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    assign summary_irq = |req;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)) else $error("read data moved"); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel.kind == RK_NONE) |=> (bus_rdata == '0)) else $error("unmapped read nonzero"); // R9
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [12:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          summary_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] rv;

    gpio_irq_bank #(.NUM_PINS(NP)) uut (
        .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
        .pad_in, .pad_out, .pad_oe, .summary_irq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung (got timeout, expected completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pad(input int p, input logic v);
        @(negedge clk);
        pad_in[p] = v;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [12:0] a_cfg(input int p);  return 13'h1000 + 13'(16*p); endfunction
    function automatic logic [12:0] a_io(input int p);   return 13'h1004 + 13'(16*p); endfunction
    function automatic logic [12:0] a_ic(input int p);   return 13'h1008 + 13'(16*p); endfunction
    function automatic logic [12:0] a_st(input int p);   return 13'h100C + 13'(16*p); endfunction
    function automatic logic [12:0] a_rt(input int p);   return 13'h0400 + 13'(4*p); endfunction

    task automatic t_reset();
        rd(a_rt(2), rv); chk("R1 route", rv, 32'd7);
        rd(a_ic(2), rv); chk("R1 irqcfg", rv, 32'd0);
        rd(a_cfg(1), rv); chk("R1 padcfg", rv, 32'd0);
        rd(a_st(0), rv); chk("R1 status", rv, 32'd0);
        chk("R1 summary", 32'(summary_irq), 32'd0);
        chk("R1 pad_oe", 32'(pad_oe), 32'd0);
    endtask

    task automatic t_pad();
        wr(a_cfg(1), 32'h200);
        wr(a_io(1), 32'h2);
        chk("R2 pad_oe", 32'(pad_oe), 32'h2);
        chk("R2 pad_out", 32'(pad_out), 32'h2);
        rd(a_cfg(1), rv); chk("R2 cfg readback", rv, 32'h200);
        pad(1, 1'b1);
        rd(a_io(1), rv); chk("R2 io level", rv, 32'h3);
    endtask

    task automatic t_edge();
        wr(a_rt(0), 32'd4);
        wr(a_ic(0), 32'hF);
        pad(0, 1'b1);
        rd(a_st(0), rv); chk("R5 rising sets", rv, 32'd1);
        chk("R5 summary", 32'(summary_irq), 32'd1);
        wr(a_st(0), 32'd0);
        rd(a_st(0), rv); chk("R4 write0 keeps", rv, 32'd1);
        wr(a_st(0), 32'd1);
        rd(a_st(0), rv); chk("R4 w1c", rv, 32'd0);
        chk("R4 summary cleared", 32'(summary_irq), 32'd0);
        pad(0, 1'b0);
        rd(a_st(0), rv); chk("R5 falling ignored", rv, 32'd0);
        wr(a_ic(0), 32'hD);
        pad(0, 1'b1);
        rd(a_st(0), rv); chk("R5 rising ignored pol0", rv, 32'd0);
        pad(0, 1'b0);
        rd(a_st(0), rv); chk("R5 falling sets pol0", rv, 32'd1);
        wr(a_st(0), 32'd1);
    endtask

    task automatic t_capture();
        wr(a_rt(2), 32'd4);
        wr(a_ic(2), 32'h7);
        pad(2, 1'b1);
        chk("R7 irq without capture", 32'(summary_irq), 32'd1);
        rd(a_st(2), rv); chk("R3 no status", rv, 32'd0);
        wr(a_st(2), 32'd1);
        chk("R7 request cleared", 32'(summary_irq), 32'd0);
        wr(a_ic(2), 32'hE);
        pad(2, 1'b0);
        pad(2, 1'b1);
        rd(a_st(2), rv); chk("R7 status without irq", rv, 32'd1);
        chk("R7 no summary", 32'(summary_irq), 32'd0);
        wr(a_st(2), 32'd1);
    endtask

    task automatic t_level();
        wr(a_rt(3), 32'd4);
        wr(a_ic(3), 32'hB);
        pad(3, 1'b1);
        rd(a_st(3), rv); chk("R6 level status", rv, 32'd1);
        chk("R6 level summary", 32'(summary_irq), 32'd1);
        wr(a_st(3), 32'd1);
        rd(a_st(3), rv); chk("R6 re-set while active", rv, 32'd1);
        pad(3, 1'b0);
        chk("R6 summary follows level", 32'(summary_irq), 32'd0);
        rd(a_st(3), rv); chk("R6 status sticky", rv, 32'd1);
        wr(a_st(3), 32'd1);
        rd(a_st(3), rv); chk("R6 cleared when inactive", rv, 32'd0);
    endtask

    task automatic t_route();
        wr(a_rt(0), 32'd7);
        pad(0, 1'b1);
        pad(0, 1'b0);
        rd(a_st(0), rv); chk("R8 status while unrouted", rv, 32'd1);
        chk("R8 blocked by code 7", 32'(summary_irq), 32'd0);
        wr(a_rt(0), 32'd4);
        chk("R8 pending delivered", 32'(summary_irq), 32'd1);
        wr(a_rt(0), 32'd5);
        chk("R8 blocked by code 5", 32'(summary_irq), 32'd0);
        wr(a_rt(0), 32'd4);
        wr(a_st(0), 32'd1);
        chk("R8 cleared", 32'(summary_irq), 32'd0);
    endtask

    task automatic t_multi();
        wr(a_ic(2), 32'hF);
        pad(2, 1'b0);
        pad(0, 1'b1);
        pad(0, 1'b0);
        pad(2, 1'b1);
        chk("R10 two pending", 32'(summary_irq), 32'd1);
        wr(a_st(0), 32'd1);
        chk("R10 one left", 32'(summary_irq), 32'd1);
        rd(a_st(2), rv); chk("R10 other status", rv, 32'd1);
        wr(a_st(2), 32'd1);
        chk("R10 none left", 32'(summary_irq), 32'd0);
    endtask

    task automatic t_bus();
        rd(13'h0800, rv); chk("R9 unmapped", rv, 32'd0);
        rd(a_st(NP), rv); chk("R9 beyond bank", rv, 32'd0);
        rd(a_rt(2), rv); chk("R9 route readback", rv, 32'd4);
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", bus_rdata, 32'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pad();
        t_edge();
        t_capture();
        t_level();
        t_route();
        t_multi();
        t_bus();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule